// File: doc/BRIEF.md
# Superframe Descrambling Sequence Generator

This block recovers clear bits from a received serial stream of a time-division superframe. At each start pulse it builds a 44-bit seed from three system identifiers: a wide-area network identifier, a system identifier and a colour code. It loads that seed into a linear feedback shift register and steps the register forward, without output, to the phase that belongs to the timeslot offset given with the start pulse. After that, every received bit that is accepted is XORed with the next bit of the sequence.

The sequence used for one superframe is 4320 bits long. It is not the natural period of the register. When the sequence index passes its last position, the register is reloaded from the stored seed, so the sequence starts again at index 0. The alignment distance is one sync length (20 bits) plus one slot stride (360 bits) per timeslot of offset.

Received bits are dropped while the generator is still being aligned, and also before the first start pulse. Deciding which bursts are scrambled, and decoding the recovered bits, belong to other blocks.

Top module: `sfd_descrambler`

## Requirements
- R1: During reset and in the first cycle after it, `out_valid_o` and `out_bit_o` are both 0.
- R2: The seed is `{network_id_i[19:0], system_id_i[11:0], color_code_i[11:0]}`, with the network identifier in bits 43:24, the system identifier in bits 23:12 and the colour code in bits 11:0. Sequence bit k is bit 43 of the register after k steps from the seed, read before the shift.
- R3: Each step shifts the register left by one bit. The new bit 0 is the XOR of register bits 43, 33, 19, 14, 8 and 3.
- R4: The first accepted received bit after a start is combined with sequence index 20 + 360 × offset. The identifiers and the offset are sampled only in the start cycle; changing them at any other time has no effect.
- R5: An offset value above 11 is treated as 11.
- R6: After sequence index 4319 the next accepted bit uses index 0, which is the seed reloaded and not the register's natural continuation.
- R7: A received bit accepted at a clock edge appears one cycle later, as `out_bit_o` = received bit XOR sequence bit, with `out_valid_o` high. `out_valid_o` is never high without an accepted bit.
- R8: Cycles in which `rx_valid_i` is low do not advance the sequence.
- R9: Received bits presented before the first start, or at any edge up to and including the edge that ends alignment, are dropped and produce no output.
- R10: A start pulse during reception restarts the block at once from the new seed and offset.
- R11: Alignment takes exactly the skip count in cycles. With the start sampled at edge e0 and skip = 20 + 360 × offset, a bit sampled at edge e(skip+1) is the first one accepted, and a bit sampled at edge e(skip) is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse: load the seed and begin alignment |
| network_id_i | input | 20 | Wide-area network identifier, sampled on start |
| system_id_i | input | 12 | System identifier, sampled on start |
| color_code_i | input | 12 | Colour code, sampled on start |
| slot_ofs_i | input | 4 | Timeslot offset from the superframe start, 0 to 11, sampled on start |
| rx_bit_i | input | 1 | Received scrambled bit |
| rx_valid_i | input | 1 | Qualifies `rx_bit_i` |
| out_bit_o | output | 1 | Descrambled bit |
| out_valid_o | output | 1 | Qualifies `out_bit_o` |

## Verification
All twelve offsets are run with two seeds whose fields differ in every identifier, so a wrong tap, a wrong field placement or a wrong stride changes the expected stream. The all-zero received pattern shows the raw sequence, and the all-one pattern shows its complement; the random pattern shows that the XOR is applied bit by bit. Offset 11 is run long enough to cross index 4319, so a register that runs on instead of reloading is caught. Idle cycles inside the stream, identifier changes after the start, an out-of-range offset, and bits sent one edge before the end of alignment each test one of the rules that something is held or ignored.

// File: rtl/sfd_pkg.sv
package sfd_pkg;

  // Alignment/reception phase of the generator
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SKIP = 2'd1,
    PH_RUN  = 2'd2
  } phase_e;

  // Clamp a timeslot offset to the highest legal slot
  function automatic int unsigned clamp_slot(input int unsigned ofs,
                                             input int unsigned max_slot);
    return (ofs > max_slot) ? max_slot : ofs;
  endfunction

endpackage

// File: rtl/sfd_seed_unit.sv
module sfd_seed_unit #(
  parameter int NET_W    = 20,
  parameter int SYS_W    = 12,
  parameter int CC_W     = 12,
  parameter int OFS_W    = 4,
  parameter int SEQ_LEN  = 4320,
  parameter int SYNC_LEN = 20,
  parameter int SLOT_LEN = 360,
  parameter int MAX_SLOT = 11,
  localparam int SR_W    = NET_W + SYS_W + CC_W,
  localparam int CNT_W   = $clog2(SEQ_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [NET_W-1:0] net_id_i,
  input  logic [SYS_W-1:0] sys_id_i,
  input  logic [CC_W-1:0]  cc_i,
  input  logic [OFS_W-1:0] ofs_i,
  output logic [SR_W-1:0]  seed_now_o,
  output logic [SR_W-1:0]  seed_q_o,
  output logic [CNT_W-1:0] skip_now_o
);
  import sfd_pkg::*;

  int unsigned slot_c;
  int unsigned dist_c;

  // Seed layout: network id high, system id middle, colour code low (R2)
  assign seed_now_o = {net_id_i, sys_id_i, cc_i};

  always_comb begin
    slot_c     = clamp_slot(int'(ofs_i), MAX_SLOT);   // R5
    dist_c     = (SYNC_LEN + SLOT_LEN * slot_c) % SEQ_LEN;
    skip_now_o = CNT_W'(dist_c);
  end

  // Seed held for reloading at the sequence wrap
  always_ff @(posedge clk) begin
    if (rst) begin
      seed_q_o <= '0;
    end else if (start_i) begin
      seed_q_o <= seed_now_o;
    end
  end

  // Identifiers only take effect in the start cycle
  assert_seed_held_R4: assert property (@(posedge clk) disable iff (rst)
    !start_i |=> $stable(seed_q_o));

  assert_seed_taken_R2: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (seed_q_o == $past(seed_now_o)));

endmodule

// File: rtl/sfd_lfsr.sv
module sfd_lfsr #(
  parameter int          SR_W     = 44,
  parameter logic [SR_W-1:0] TAP_MASK = 44'h802_0008_4108,
  parameter int          SEQ_LEN  = 4320,
  localparam int         CNT_W    = $clog2(SEQ_LEN),
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SEQ_LEN - 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_i,
  input  logic [SR_W-1:0] load_val_i,
  input  logic            step_i,
  input  logic [SR_W-1:0] wrap_val_i,
  output logic            seq_bit_o
);

  logic [SR_W-1:0]  sr_q;
  logic [CNT_W-1:0] pos_q;
  logic [SR_W-1:0]  tap_bits;
  logic             fb;

  // Feedback taps selected by the mask, one XOR term per set bit (R3)
  genvar g;
  generate
    for (g = 0; g < SR_W; g++) begin : g_tap
      if (TAP_MASK[g]) begin : g_use
        assign tap_bits[g] = sr_q[g];
      end else begin : g_skip
        assign tap_bits[g] = 1'b0;
      end
    end
  endgenerate

  assign fb        = ^tap_bits;
  assign seq_bit_o = sr_q[SR_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q  <= '0;
      pos_q <= '0;
    end else if (load_i) begin
      sr_q  <= load_val_i;
      pos_q <= '0;
    end else if (step_i) begin
      if (pos_q == LAST) begin
        sr_q  <= wrap_val_i;            // R6: restart from the seed
        pos_q <= '0;
      end else begin
        sr_q  <= {sr_q[SR_W-2:0], fb};
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  assert_pos_bound_R6: assert property (@(posedge clk) disable iff (rst)
    pos_q <= LAST);

  assert_wrap_reload_R6: assert property (@(posedge clk) disable iff (rst)
    (step_i && !load_i && pos_q == LAST) |=> (pos_q == '0 && sr_q == $past(wrap_val_i)));

  assert_shift_left_R3: assert property (@(posedge clk) disable iff (rst)
    (step_i && !load_i && pos_q != LAST) |=> (sr_q[SR_W-1:1] == $past(sr_q[SR_W-2:0])));

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!step_i && !load_i) |=> ($stable(sr_q) && $stable(pos_q)));

endmodule

// File: rtl/sfd_phase_ctrl.sv
module sfd_phase_ctrl #(
  parameter int SEQ_LEN = 4320,
  localparam int CNT_W  = $clog2(SEQ_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  skip_i,
  input  logic              rx_valid_i,
  output logic              step_o,
  output logic              accept_o,
  output sfd_pkg::phase_e   phase_o
);
  import sfd_pkg::*;

  phase_e           ph_q;
  logic [CNT_W-1:0] cnt_q;

  assign phase_o  = ph_q;
  assign accept_o = !start_i && (ph_q == PH_RUN) && rx_valid_i;
  assign step_o   = !start_i && ((ph_q == PH_SKIP) || accept_o);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q <= skip_i;
      ph_q  <= (skip_i == '0) ? PH_RUN : PH_SKIP;   // R10: restart at once
    end else if (ph_q == PH_SKIP) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) begin
        ph_q <= PH_RUN;                              // R11
      end
    end
  end

  assert_skip_count_R11: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_SKIP) |-> (cnt_q != '0));

  assert_start_leaves_idle_R4: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (ph_q != PH_IDLE));

  assert_skip_drops_R9: assert property (@(posedge clk) disable iff (rst)
    (ph_q != PH_RUN) |-> !accept_o);

endmodule

// File: rtl/sfd_descrambler.sv
module sfd_descrambler #(
  parameter int NET_W    = 20,
  parameter int SYS_W    = 12,
  parameter int CC_W     = 12,
  parameter int OFS_W    = 4,
  parameter int SEQ_LEN  = 4320,
  parameter int SYNC_LEN = 20,
  parameter int SLOT_LEN = 360,
  parameter int MAX_SLOT = 11,
  parameter logic [NET_W+SYS_W+CC_W-1:0] TAP_MASK = 44'h802_0008_4108
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [NET_W-1:0] network_id_i,
  input  logic [SYS_W-1:0] system_id_i,
  input  logic [CC_W-1:0]  color_code_i,
  input  logic [OFS_W-1:0] slot_ofs_i,
  input  logic             rx_bit_i,
  input  logic             rx_valid_i,
  output logic             out_bit_o,
  output logic             out_valid_o
);
  import sfd_pkg::*;

  localparam int SR_W  = NET_W + SYS_W + CC_W;
  localparam int CNT_W = $clog2(SEQ_LEN);

  logic [SR_W-1:0]  seed_now;
  logic [SR_W-1:0]  seed_q;
  logic [CNT_W-1:0] skip_now;
  logic             step;
  logic             accept;
  logic             seq_bit;
  phase_e           phase;

  sfd_seed_unit #(
    .NET_W(NET_W), .SYS_W(SYS_W), .CC_W(CC_W), .OFS_W(OFS_W),
    .SEQ_LEN(SEQ_LEN), .SYNC_LEN(SYNC_LEN), .SLOT_LEN(SLOT_LEN),
    .MAX_SLOT(MAX_SLOT)
  ) i_seed (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .net_id_i   (network_id_i),
    .sys_id_i   (system_id_i),
    .cc_i       (color_code_i),
    .ofs_i      (slot_ofs_i),
    .seed_now_o (seed_now),
    .seed_q_o   (seed_q),
    .skip_now_o (skip_now)
  );

  sfd_phase_ctrl #(.SEQ_LEN(SEQ_LEN)) i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .skip_i     (skip_now),
    .rx_valid_i (rx_valid_i),
    .step_o     (step),
    .accept_o   (accept),
    .phase_o    (phase)
  );

  sfd_lfsr #(.SR_W(SR_W), .TAP_MASK(TAP_MASK), .SEQ_LEN(SEQ_LEN)) i_lfsr (
    .clk        (clk),
    .rst        (rst),
    .load_i     (start_i),
    .load_val_i (seed_now),
    .step_i     (step),
    .wrap_val_i (seed_q),
    .seq_bit_o  (seq_bit)
  );

  // Registered output stage (R7)
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_o <= 1'b0;
      out_bit_o   <= 1'b0;
    end else begin
      out_valid_o <= accept;
      if (accept) begin
        out_bit_o <= rx_bit_i ^ seq_bit;
      end
    end
  end

  assert_out_needs_input_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid_o |-> $past(rx_valid_i && !start_i));

  assert_out_only_in_run_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid_o |-> ($past(phase) == PH_RUN));

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid_o && !out_bit_o));

endmodule

// File: tb/test_sfd_descrambler.sv
module test_sfd_descrambler;
  localparam int L = 4320;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [19:0] network_id_i = '0;
  logic [11:0] system_id_i = '0;
  logic [11:0] color_code_i = '0;
  logic [3:0]  slot_ofs_i = '0;
  logic        rx_bit_i = 1'b0;
  logic        rx_valid_i = 1'b0;
  logic        out_bit_o;
  logic        out_valid_o;

  int checks = 0;
  int errors = 0;
  bit seq_m [0:L-1];

  always #5 clk = ~clk;

  sfd_descrambler i_sfd_descrambler (
    .clk(clk), .rst(rst), .start_i(start_i),
    .network_id_i(network_id_i), .system_id_i(system_id_i),
    .color_code_i(color_code_i), .slot_ofs_i(slot_ofs_i),
    .rx_bit_i(rx_bit_i), .rx_valid_i(rx_valid_i),
    .out_bit_o(out_bit_o), .out_valid_o(out_valid_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Software model of the sequence: seed fields, taps, 4320-bit period
  task automatic build_model(input logic [19:0] n, input logic [11:0] s, input logic [11:0] c);
    longint unsigned r;
    bit f;
    r = {20'd0, n, s, c};
    for (int i = 0; i < L; i++) begin
      seq_m[i] = r[43];
      f = r[43] ^ r[33] ^ r[19] ^ r[14] ^ r[8] ^ r[3];
      r = ((r << 1) | longint'(f)) & 64'h0000_0FFF_FFFF_FFFF;
    end
  endtask

  function automatic bit gen_bit(input int pat);
    if (pat == 0) return 1'b0;
    if (pat == 1) return 1'b1;
    return 1'($urandom_range(0, 1));
  endfunction

  // One start plus a stream of nbits accepted bits
  task automatic run(input logic [19:0] n, input logic [11:0] s, input logic [11:0] c,
                     input logic [3:0] ofs, input int skip, input int nbits, input int pat);
    int j;
    int cyc;
    bit pend;
    bit eb;
    bit d;
    build_model(n, s, c);
    @(negedge clk);
    start_i = 1'b1; network_id_i = n; system_id_i = s; color_code_i = c;
    slot_ofs_i = ofs; rx_valid_i = 1'b0;
    @(negedge clk);               // after e0
    start_i = 1'b0;
    network_id_i = ~n; system_id_i = ~s; color_code_i = ~c; slot_ofs_i = 4'd3; // R4: ignored
    repeat (skip - 1) @(negedge clk);
    rx_valid_i = 1'b1; rx_bit_i = 1'b1; // sampled at e(skip): must drop
    @(negedge clk);
    check(out_valid_o == 1'b0, "R9/R11 bit at end of alignment dropped", int'(out_valid_o), 0);
    d = gen_bit(pat);
    rx_bit_i = d;
    eb = d ^ seq_m[skip % L];
    pend = 1'b1; j = 1; cyc = 0;
    while (pend) begin
      @(negedge clk);
      check(out_valid_o == 1'b1, "R7/R11 output strobe", int'(out_valid_o), 1);
      check(out_bit_o == eb, "R2/R3/R4/R6 descrambled bit", int'(out_bit_o), int'(eb));
      pend = 1'b0;
      while (!pend && j < nbits) begin
        cyc++;
        if (cyc % 7 == 3) begin
          rx_valid_i = 1'b0;
          @(negedge clk);
          check(out_valid_o == 1'b0, "R8 idle cycle gives no output", int'(out_valid_o), 0);
        end else begin
          d = gen_bit(pat);
          rx_valid_i = 1'b1; rx_bit_i = d;
          eb = d ^ seq_m[(skip + j) % L];
          j++; pend = 1'b1;
        end
      end
    end
    rx_valid_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid_o == 1'b0 && out_bit_o == 1'b0, "R1 reset state", int'({out_valid_o, out_bit_o}), 0);
    @(negedge clk);
    rst = 1'b0;
    check(out_valid_o == 1'b0, "R1 after reset", int'(out_valid_o), 0);
    // R9: bits before any start are dropped
    rx_valid_i = 1'b1; rx_bit_i = 1'b1;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      check(out_valid_o == 1'b0, "R9 no output before start", int'(out_valid_o), 0);
    end
    rx_valid_i = 1'b0;
    // Full offset sweep, two seeds, three patterns (R10: each start cuts a running stream)
    for (int o = 0; o < 12; o++)
      run(20'hB5A3C, 12'h6E1, 12'h293, 4'(o), 20 + 360 * o, 420, o % 3);
    for (int o = 0; o < 12; o++)
      run(20'h1F00D, 12'hC47, 12'h9AE, 4'(o), 20 + 360 * o, 420, 2);
    // R6: offset 11 streamed past index 4319
    run(20'h7C3E5, 12'h018, 12'hF42, 4'd11, 3980, 900, 0);
    run(20'h7C3E5, 12'h018, 12'hF42, 4'd11, 3980, 900, 2);
    // R5: out-of-range offsets behave as 11
    run(20'hB5A3C, 12'h6E1, 12'h293, 4'd13, 3980, 400, 2);
    run(20'h1F00D, 12'hC47, 12'h9AE, 4'd15, 3980, 400, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule